// File: doc/BRIEF.md
# Serial Peripheral Byte Engine with Dual-Line Write

This block is a serial peripheral bus master that moves one byte at a time between a host and a device. Bytes always leave most significant bit first. In the normal mode one bit leaves per serial clock on the primary data output, and the input line is sampled into a receive register. In the dual-line write mode each serial clock carries two bits, one on the primary output and one on a secondary output, so a byte needs four clocks instead of eight.

The serial clock comes from an internal divider set by `cfg_div`. The host offers bytes on a valid/ready stream (`tx_valid`, `tx_ready`, `tx_data`, `tx_last`). A byte moves only in a cycle where both valid and ready are high. Ready is high only while the engine is idle, so the host must hold valid and data until it sees ready. The receive side has no back-pressure: `rx_valid` is a one-cycle pulse and the consumer must take `rx_data` in that cycle. The first accepted byte opens a transfer on the chip-select line picked by the device index. The chip select then stays asserted until the byte marked last, or a failed compare, closes the transfer. After that comes a fixed gap with both selects released.

In verify mode the engine sends zeros and compares each received byte with the byte the host supplied. On the first mismatch it reports how many bytes matched and ends the transfer.

Top module: `spi_dual_master`

## Requirements
- R1: In normal mode each byte is sent MSB first as eight SCK pulses. `mosi` changes only while SCK is low and holds steady while SCK is high. `mosi2` stays 0 in normal mode.
- R2: In dual-line write mode a byte takes four SCK pulses. On each pulse `mosi` carries the higher bit of the pair and `mosi2` the lower one, in the order (7,6), (5,4), (3,2), (1,0).
- R3: Each SCK low phase and each SCK high phase lasts L+1 clock cycles, where L = `cfg_div`. A `cfg_div` of 0 is treated as 1.
- R4: `miso` is sampled when SCK rises, filling `rx_data` MSB first. `rx_valid` pulses for one cycle at the end of the byte's last high phase. In dual-line mode the four samples fill `rx_data[3:0]` and the upper bits read 0.
- R5: With active-low polarity (`cfg_cs_high`=0), device index 2 drives `cs_n[1]` low and any other index drives `cs_n[0]` low. With active-high polarity both lines stay high. Device and polarity are latched when a transfer opens.
- R6: The chip select stays asserted between the bytes of one transfer. After the byte sent with `tx_last`=1 completes, both `cs_n` lines are high, and no byte is accepted for GAP_CYC cycles.
- R7: In verify mode (`cfg_verify`=1) zeros are shifted out, and each received byte is compared with its `tx_data`. On a mismatch `vfy_err` pulses together with `rx_valid`, `vfy_count` gives the number of bytes that matched before it in the transfer, and the transfer closes as in R6.
- R8: `tx_ready` is high only when the engine is idle and not in the gap. `busy` is its complement after reset.
- R9: After a synchronous reset SCK is low, both `cs_n` lines are high, `mosi` and `mosi2` are 0, `rx_valid` is 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | DIV_W | Phase length control (0 acts as 1) |
| cfg_dev | input | 2 | Device index selecting the chip-select line |
| cfg_cs_high | input | 1 | Device uses active-high select |
| cfg_fast | input | 1 | Dual-line write mode |
| cfg_verify | input | 1 | Verify mode |
| tx_valid | input | 1 | Byte offered by host |
| tx_ready | output | 1 | Engine accepts a byte this cycle |
| tx_data | input | 8 | Byte to send, or expected byte in verify mode |
| tx_last | input | 1 | Byte closes the transfer |
| rx_valid | output | 1 | One-cycle done pulse |
| rx_data | output | 8 | Received byte |
| vfy_err | output | 1 | Verify mismatch, with rx_valid |
| vfy_count | output | CNT_W | Bytes matched in the current transfer |
| busy | output | 1 | Byte in flight or gap running |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Primary data out |
| mosi2 | output | 1 | Secondary data out (dual-line mode) |
| miso | input | 1 | Data in |
| cs_n | output | 2 | Chip-select lines |

## Verification
The hardest case to reach is a verify mismatch in the middle of a transfer. The count it reports depends on earlier bytes having matched under a chip select that stayed low the whole time. The bench models a device that returns a programmed byte on `miso`. It runs a three-byte verify transfer whose first two bytes agree and whose third does not. It then checks the count, the error pulse, the zero data on `mosi`, and that the select releases for the gap even though the host never marked a last byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_GAP  = 2'd3
  } spim_state_e;
endpackage

// File: rtl/spim_phase.sv
module spim_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             phase_end
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt;

  assign lim       = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign phase_end = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (phase_end) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R3
  min_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> !phase_end);
endmodule

// File: rtl/spim_csel.sv
module spim_csel (
  input  logic       clk,
  input  logic       rst,
  input  logic       open,
  input  logic       close,
  input  logic [1:0] dev,
  input  logic       pol_high,
  output logic       act,
  output logic [1:0] cs_n
);
  logic line_r;
  logic hi_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      line_r <= 1'b0;
      hi_r   <= 1'b0;
    end else if (open) begin
      act    <= 1'b1;
      line_r <= (dev == 2'd2);
      hi_r   <= pol_high;
    end else if (close) begin
      act    <= 1'b0;
    end
  end

  always_comb begin
    cs_n = 2'b11;
    if (act && !hi_r) cs_n[line_r] = 1'b0;
  end

  // R6
  close_release_chk: assert property (@(posedge clk) disable iff (rst)
    close |=> (cs_n == 2'b11));
endmodule

// File: rtl/spi_dual_master.sv
module spi_dual_master
  import spim_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_dev,
  input  logic             cfg_cs_high,
  input  logic             cfg_fast,
  input  logic             cfg_verify,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  input  logic             tx_last,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             vfy_err,
  output logic [CNT_W-1:0] vfy_count,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             mosi2,
  input  logic             miso,
  output logic [1:0]       cs_n
);
  localparam int GW = $clog2(GAP_CYC + 1);

  spim_state_e state;
  logic [7:0]  sh, rxs, exp_r;
  logic [3:0]  bcnt;
  logic        last_r, fast_r, vfy_r;
  logic [GW-1:0] gcnt;
  logic        run, phase_end, accept, done, mism, cs_act, open, close;

  assign run      = (state == ST_LOW) || (state == ST_HIGH);
  assign tx_ready = (state == ST_IDLE);
  assign busy     = !tx_ready;
  assign accept   = tx_valid && tx_ready;
  assign open     = accept && !cs_act;
  assign done     = (state == ST_HIGH) && phase_end && (bcnt == 4'd1);
  assign mism     = done && vfy_r && (rxs != exp_r);
  assign close    = done && (last_r || mism);

  assign sck     = (state == ST_HIGH);
  assign mosi    = run && sh[7];
  assign mosi2   = run && fast_r && sh[6];
  assign rx_data = rxs;

  spim_phase #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .run(run), .cfg_div(cfg_div), .phase_end(phase_end)
  );

  spim_csel u_csel (
    .clk(clk), .rst(rst), .open(open), .close(close), .dev(cfg_dev),
    .pol_high(cfg_cs_high), .act(cs_act), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sh        <= '0;
      rxs       <= '0;
      exp_r     <= '0;
      bcnt      <= '0;
      last_r    <= 1'b0;
      fast_r    <= 1'b0;
      vfy_r     <= 1'b0;
      gcnt      <= '0;
      rx_valid  <= 1'b0;
      vfy_err   <= 1'b0;
      vfy_count <= '0;
    end else begin
      rx_valid <= 1'b0;
      vfy_err  <= 1'b0;
      if (open) vfy_count <= '0;
      unique case (state)
        ST_IDLE: if (accept) begin
          sh     <= cfg_verify ? 8'h00 : tx_data;
          exp_r  <= tx_data;
          rxs    <= '0;
          fast_r <= cfg_fast && !cfg_verify;
          vfy_r  <= cfg_verify;
          last_r <= tx_last;
          bcnt   <= (cfg_fast && !cfg_verify) ? 4'd4 : 4'd8;
          state  <= ST_LOW;
        end
        ST_LOW: if (phase_end) begin
          rxs   <= {rxs[6:0], miso};
          state <= ST_HIGH;
        end
        ST_HIGH: if (phase_end) begin
          sh   <= fast_r ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
          bcnt <= bcnt - 1'b1;
          if (bcnt == 4'd1) begin
            rx_valid <= 1'b1;
            vfy_err  <= mism;
            if (vfy_r && !mism) vfy_count <= vfy_count + 1'b1;
            gcnt  <= '0;
            state <= close ? ST_GAP : ST_IDLE;
          end else begin
            state <= ST_LOW;
          end
        end
        ST_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP_CYC - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi) && $stable(mosi2));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    vfy_err |-> rx_valid);
  // R6
  gap_block_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_act) |-> !tx_ready);
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !sck && !mosi && !mosi2);
endmodule

// File: tb/spi_dual_master_tb.sv
module spi_dual_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] cfg_div = 8'd2;
  logic [1:0] cfg_dev = 2'd0;
  logic cfg_cs_high = 1'b0, cfg_fast = 1'b0, cfg_verify = 1'b0;
  logic tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, vfy_err, busy, sck, mosi, mosi2, miso;
  logic [7:0] rx_data, vfy_count;
  logic [1:0] cs_n;

  int checks = 0, fails = 0;
  logic [7:0] sreg = 8'h00, cap_a = 8'h00, cap_b = 8'h00;
  int rises = 0, hi_cyc = 0;
  logic [1:0] cs_seen = 2'b11;
  logic got_err = 1'b0;
  logic [7:0] got_rx = 8'h00, got_cnt = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dual_master #(.DIV_W(8), .GAP_CYC(GAP), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_dev(cfg_dev),
    .cfg_cs_high(cfg_cs_high), .cfg_fast(cfg_fast), .cfg_verify(cfg_verify),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .vfy_err(vfy_err), .vfy_count(vfy_count),
    .busy(busy), .sck(sck), .mosi(mosi), .mosi2(mosi2), .miso(miso), .cs_n(cs_n)
  );

  assign miso = sreg[7];
  always @(negedge sck) sreg <= {sreg[6:0], 1'b0};
  always @(posedge sck) begin
    cap_a <= {cap_a[6:0], mosi};
    cap_b <= {cap_b[6:0], mosi2};
    rises <= rises + 1;
  end
  always @(negedge clk) if (sck) begin
    hi_cyc  <= hi_cyc + 1;
    cs_seen <= cs_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Send one byte with the device returning dev_byte; wait for its done pulse.
  task automatic xfer(input logic [7:0] d, input logic last, input logic [7:0] dev_byte);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    sreg = dev_byte; cap_a = 0; cap_b = 0; rises = 0; hi_cyc = 0;
    tx_valid = 1'b1; tx_data = d; tx_last = last;
    @(negedge clk);
    tx_valid = 1'b0;
    while (!rx_valid) @(negedge clk);
    got_rx = rx_data; got_err = vfy_err; got_cnt = vfy_count;
  endtask

  task automatic t_reset();
    check("R9 sck", sck, 0);
    check("R9 cs_n", cs_n, 2'b11);
    check("R9 mosi", {mosi, mosi2}, 0);
    check("R9 rx_valid", rx_valid, 0);
    check("R9 tx_ready", tx_ready, 1);
    check("R8 busy", busy, 0);
  endtask

  task automatic t_normal();
    cfg_div = 8'd2; cfg_dev = 2'd0;
    xfer(8'hA5, 1'b0, 8'h3C);
    check("R1 mosi bits", cap_a, 8'hA5);
    check("R1 mosi2 idle", cap_b, 8'h00);
    check("R1 pulses", rises, 8);
    check("R3 high cycles div2", hi_cyc, 24);
    check("R4 rx_data", got_rx, 8'h3C);
    check("R5 cs line0", cs_seen, 2'b10);
    @(negedge clk);
    check("R4 pulse one cycle", rx_valid, 0);
    check("R6 cs held between bytes", cs_n, 2'b10);
    check("R8 ready after byte", tx_ready, 1);
    xfer(8'h5A, 1'b1, 8'hC3);
    check("R4 rx second", got_rx, 8'hC3);
    check("R6 cs released", cs_n, 2'b11);
    begin
      int n = 0;
      while (!tx_ready) begin n++; @(negedge clk); end
      check("R6 gap length", n, GAP);
    end
  endtask

  task automatic t_dev2_div0();
    cfg_div = 8'd0; cfg_dev = 2'd2;
    xfer(8'h81, 1'b1, 8'hFF);
    check("R5 cs line1", cs_seen, 2'b01);
    check("R3 high cycles div0", hi_cyc, 16);
    check("R1 data dev2", cap_a, 8'h81);
  endtask

  task automatic t_cs_high();
    cfg_div = 8'd1; cfg_dev = 2'd0; cfg_cs_high = 1'b1;
    xfer(8'h0F, 1'b1, 8'h00);
    check("R5 active-high both high", cs_seen, 2'b11);
    cfg_cs_high = 1'b0;
  endtask

  task automatic t_fast();
    cfg_div = 8'd3; cfg_fast = 1'b1;
    xfer(8'hB4, 1'b1, 8'hA0);
    check("R2 pulses", rises, 4);
    check("R2 mosi high bits", cap_a[3:0], 4'b1100);
    check("R2 mosi2 low bits", cap_b[3:0], 4'b0110);
    check("R3 high cycles div3", hi_cyc, 16);
    check("R4 fast rx nibble", got_rx, 8'h0A);
    cfg_fast = 1'b0;
  endtask

  task automatic t_verify();
    logic [7:0] a0;
    cfg_div = 8'd1; cfg_verify = 1'b1;
    xfer(8'h11, 1'b0, 8'h11);
    a0 = cap_a;
    check("R7 match no err", got_err, 0);
    xfer(8'h22, 1'b0, 8'h22);
    check("R7 count after two", got_cnt, 2);
    xfer(8'h33, 1'b0, 8'h99);
    check("R7 mismatch err", got_err, 1);
    check("R7 matched count", got_cnt, 2);
    check("R7 zeros sent", a0 | cap_a, 0);
    check("R7 transfer closed", cs_n, 2'b11);
    check("R7 gap busy", tx_ready, 0);
    cfg_verify = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_dev2_div0();
    t_cs_high();
    t_fast();
    t_verify();
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule